// File: doc/BRIEF.md
# PLL calibration and mode controller

This block supervises a crystal-oscillator PLL. It takes the board-level control pins and works out one of three operating policies. In the first, calibration runs only after a reset. In the second, calibration runs after a reset and again after every loss of lock. In the third, the automatic calibration is off and the pins choose the oscillator range directly.

The mode pin changes what two other pins mean. While the mode pin is high, the restart-enable pin and the active-low reset pin become the top two bits of a 6-bit oscillator range code. While it is low, the range-select pins are ignored and the range code comes from the calibration engine.

The block asks the calibration engine for a cycle with a single-cycle request and then waits for the engine's done strobe. It also produces the lock output the board sees. In the two automatic modes that output is a debounced version of the raw lock flag; in the manual mode the raw flag passes straight through.

Top module: `pll_cal_supervisor`

## Requirements
- R1: Every control pin (mode, restart-enable/bit 4, reset/bit 5, range bits 3..0) passes through two flip-flops, so a pin change first shows at the outputs after the second rising clock edge that samples it.
- R2: In manual mode (synchronised mode pin = 1), `range_code` bit 5 is the reset pin, bit 4 is the restart-enable pin, and bits 3..0 are `range_lo_pin`.
- R3: In either automatic mode (synchronised mode pin = 0), `range_code` equals `cal_code`, and the range-select pins have no effect on it.
- R4: `cal_start` is high for exactly one cycle per request. No further request is made until `cal_done` has been seen high, which may happen in the same cycle as the request.
- R5: In the automatic modes a calibration is requested after power-on reset is released, and again when the reset pin returns high after being low. No request is made while the reset pin is held low.
- R6: With restart enabled (automatic mode 1), every fall of the filtered lock starts a new calibration request. With restart disabled (automatic mode 0), a loss of lock requests nothing.
- R7: In manual mode no calibration is ever requested, and events from that period are not carried over into the automatic modes.
- R8: In the automatic modes `locked` rises after `lock_raw` has been high for LOCK_ON_CNT consecutive clocks, and falls after it has been low for LOCK_OFF_CNT consecutive clocks.
- R9: In manual mode `locked` follows `lock_raw` combinationally.
- R10: While `por_n` is low the synchronisers hold the pin defaults: mode 0, restart-enable 1, reset 1, range bits 3..0 = 4'b1000. `cal_start` and `locked` are 0, and `range_code` equals `cal_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_ctrl_pin | input | 1 | Mode pin: 1 selects manual range control |
| auto_rst_pin | input | 1 | Restart enable; becomes range bit 4 in manual mode |
| rst_n_pin | input | 1 | Active-low calibration reset; becomes range bit 5 in manual mode |
| range_lo_pin | input | 4 | Range bits 3..0 (used in manual mode only) |
| lock_raw | input | 1 | Instantaneous lock flag from the phase detector |
| cal_done | input | 1 | Strobe from the calibration engine at the end of a cycle |
| cal_code | input | 6 | Range code found by the calibration engine |
| range_code | output | 6 | Range code applied to the oscillator |
| cal_start | output | 1 | One-cycle calibration request |
| locked | output | 1 | Lock indication: filtered in the automatic modes, raw in manual mode |

## Verification
The bench runs directed passes through each mode. In each pass it drops the lock and pulses the reset pin, then compares the number of calibration requests to the count the mode's policy allows. This separates "after reset only", "after every loss" and "never". A one-edge-versus-two-edge probe on a range pin separates a correct two-stage synchroniser from a shorter or longer one. A long random run then flips the lock flag and reshuffles the pins against a bench model of the filter counts and the request policy, which catches off-by-one filter lengths and requests that are lost or duplicated around the done strobe.

// File: rtl/pll_cal_supervisor.sv
module pll_cal_supervisor #(
  parameter int LOCK_ON_CNT  = 16,
  parameter int LOCK_OFF_CNT = 8,
  parameter int LO_W         = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_ctrl_pin,
  input  logic              auto_rst_pin,
  input  logic              rst_n_pin,
  input  logic [LO_W-1:0]   range_lo_pin,
  input  logic              lock_raw,
  input  logic              cal_done,
  input  logic [LO_W+1:0]   cal_code,
  output logic [LO_W+1:0]   range_code,
  output logic              cal_start,
  output logic              locked
);
  localparam int RANGE_W = LO_W + 2;
  localparam int PW      = LO_W + 3;
  localparam int MAXC    = (LOCK_ON_CNT > LOCK_OFF_CNT) ? LOCK_ON_CNT : LOCK_OFF_CNT;
  localparam int CW      = $clog2(MAXC + 1);
  localparam logic [PW-1:0] PIN_DEF = {1'b0, 1'b1, 1'b1, 1'b1, {(LO_W-1){1'b0}}};

  logic [PW-1:0] pin_s1, pin_s2;
  logic          filt_q, need_q, busy_q, start_q;
  logic [CW-1:0] run_q;

  wire ext_q  = pin_s2[PW-1];
  wire rstn_q = pin_s2[PW-2];
  wire auto_q = pin_s2[PW-3];

  assign range_code = ext_q ? pin_s2[RANGE_W-1:0] : cal_code;
  assign locked     = ext_q ? lock_raw : filt_q;
  assign cal_start  = start_q;

  wire          differ = lock_raw ^ filt_q;
  wire [CW-1:0] lim    = filt_q ? CW'(LOCK_OFF_CNT - 1) : CW'(LOCK_ON_CNT - 1);
  wire          flip   = differ && (run_q == lim);

  wire issue  = need_q & ~busy_q & rstn_q & ~ext_q;
  wire loss   = auto_q & filt_q & flip;
  wire need_d = ext_q ? 1'b0 : (~rstn_q | loss | (need_q & ~issue));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_s1  <= PIN_DEF;
      pin_s2  <= PIN_DEF;
      filt_q  <= 1'b0;
      run_q   <= '0;
      need_q  <= 1'b1;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pin_s1  <= {ext_ctrl_pin, rst_n_pin, auto_rst_pin, range_lo_pin};
      pin_s2  <= pin_s1;
      filt_q  <= filt_q ^ flip;
      run_q   <= (!differ || flip) ? '0 : run_q + 1'b1;
      need_q  <= need_d;
      busy_q  <= issue | (busy_q & ~cal_done);
      start_q <= issue;
    end
  end
endmodule

// File: rtl/pll_cal_supervisor_chk.sv
module pll_cal_supervisor_chk #(
  parameter int LO_W = 4
) (
  input logic              clk,
  input logic              por_n,
  input logic              ext_ctrl_pin,
  input logic              auto_rst_pin,
  input logic              rst_n_pin,
  input logic [LO_W-1:0]   range_lo_pin,
  input logic              lock_raw,
  input logic              cal_done,
  input logic [LO_W+1:0]   cal_code,
  input logic [LO_W+1:0]   range_code,
  input logic              cal_start,
  input logic              locked
);
  logic [2:0] warm;
  logic       outstanding;
  wire        ready = (warm == 3'd7);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      warm        <= '0;
      outstanding <= 1'b0;
    end else begin
      if (!ready) warm <= warm + 1'b1;
      outstanding <= cal_start ? ~cal_done : (outstanding & ~cal_done);
    end
  end

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!por_n)
    cal_start |=> !cal_start);

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!por_n)
    cal_start |-> !outstanding);

  a_r7_no_req_manual: assert property (@(posedge clk) disable iff (!por_n || !ready)
    $past(ext_ctrl_pin, 3) |-> !cal_start);

  a_r2_manual_range: assert property (@(posedge clk) disable iff (!por_n || !ready)
    $past(ext_ctrl_pin, 2) |->
      range_code == {$past(rst_n_pin, 2), $past(auto_rst_pin, 2), $past(range_lo_pin, 2)});

  a_r3_auto_range: assert property (@(posedge clk) disable iff (!por_n || !ready)
    !$past(ext_ctrl_pin, 2) |-> range_code == cal_code);

  a_r9_raw_lock: assert property (@(posedge clk) disable iff (!por_n || !ready)
    $past(ext_ctrl_pin, 2) |-> locked == lock_raw);

  a_r8_rise_needs_high: assert property (@(posedge clk) disable iff (!por_n || !ready)
    ($rose(locked) && !$past(ext_ctrl_pin, 2) && !$past(ext_ctrl_pin, 3)) |-> $past(lock_raw));
endmodule

bind pll_cal_supervisor pll_cal_supervisor_chk #(.LO_W(LO_W)) u_chk (
  .clk(clk), .por_n(por_n), .ext_ctrl_pin(ext_ctrl_pin), .auto_rst_pin(auto_rst_pin),
  .rst_n_pin(rst_n_pin), .range_lo_pin(range_lo_pin), .lock_raw(lock_raw),
  .cal_done(cal_done), .cal_code(cal_code), .range_code(range_code),
  .cal_start(cal_start), .locked(locked)
);

// File: tb/tb_pll_cal_supervisor.sv
module tb_pll_cal_supervisor;
  localparam int N = 4;
  localparam int M = 3;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_ctrl_pin = 1'b0, auto_rst_pin = 1'b1, rst_n_pin = 1'b1;
  logic [3:0] range_lo_pin = 4'b1000;
  logic       lock_raw = 1'b0, cal_done = 1'b0;
  logic [5:0] cal_code = 6'h2A;
  logic [5:0] range_code;
  logic       cal_start, locked;

  pll_cal_supervisor #(.LOCK_ON_CNT(N), .LOCK_OFF_CNT(M), .LO_W(4)) dut (
    .clk(clk), .por_n(por_n), .ext_ctrl_pin(ext_ctrl_pin), .auto_rst_pin(auto_rst_pin),
    .rst_n_pin(rst_n_pin), .range_lo_pin(range_lo_pin), .lock_raw(lock_raw),
    .cal_done(cal_done), .cal_code(cal_code), .range_code(range_code),
    .cal_start(cal_start), .locked(locked));

  always #5 clk = ~clk;

  int errors = 0, checks = 0, n_starts = 0;
  bit cmp_on = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench model: {mode, reset, restart, range[3:0]} after two sync stages
  logic [6:0] m_s1 = 7'b0111000, m_s2 = 7'b0111000;
  logic m_filt = 0, m_need = 1, m_busy = 0, m_cs = 0;
  int   m_run = 0;

  function automatic logic [5:0] exp_range(logic [6:0] s, logic [5:0] cc);
    return s[6] ? s[5:0] : cc;
  endfunction

  function automatic logic exp_lock(logic [6:0] s, logic f, logic raw);
    return s[6] ? raw : f;
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_s1 = 7'b0111000; m_s2 = 7'b0111000;
      m_filt = 0; m_need = 1; m_busy = 0; m_cs = 0; m_run = 0;
    end else begin
      logic ext, rstn, aut, issue, loss, nf;
      ext = m_s2[6]; rstn = m_s2[5]; aut = m_s2[4];
      nf = m_filt;
      if (lock_raw != m_filt) begin
        m_run++;
        if (m_run >= (m_filt ? M : N)) begin nf = ~m_filt; m_run = 0; end
      end else m_run = 0;
      issue = m_need && !m_busy && rstn && !ext;
      loss  = m_filt && !nf && aut;
      m_need = ext ? 1'b0 : ((!rstn) || loss || (m_need && !issue));
      m_busy = issue || (m_busy && !cal_done);
      m_cs   = issue;
      m_filt = nf;
      m_s2 = m_s1;
      m_s1 = {ext_ctrl_pin, rst_n_pin, auto_rst_pin, range_lo_pin};
    end
    #2;
    if (cal_start === 1'b1) n_starts++;
    if (cmp_on) begin
      chk(m_s2[6] ? "R2" : "R3", range_code, exp_range(m_s2, cal_code));
      chk(m_s2[6] ? "R9" : "R8", locked, exp_lock(m_s2, m_filt, lock_raw));
      chk("R4", cal_start, m_cs);
    end
  end

  // calibration engine stand-in
  always begin
    @(posedge clk); #3;
    if (cal_start === 1'b1) begin
      repeat ($urandom_range(0, 7)) @(negedge clk);
      cal_done = 1'b1;
      @(negedge clk);
      cal_done = 1'b0;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'h5EED_0042));
    // R10: reset holds defaults even with pins driven away from them
    ext_ctrl_pin = 1'b1; range_lo_pin = 4'b0000; lock_raw = 1'b1;
    cyc(4);
    chk("R10", range_code, cal_code);
    chk("R10", locked, 1'b0);
    chk("R10", cal_start, 1'b0);
    ext_ctrl_pin = 1'b0; range_lo_pin = 4'b1000; lock_raw = 1'b0;
    cyc(2);
    cmp_on = 1;
    base = n_starts;
    por_n = 1'b1;
    cyc(20);
    chk("R5", n_starts - base, 1);

    // R6: mode 0 ignores lock loss
    auto_rst_pin = 1'b0; cyc(5);
    base = n_starts;
    lock_raw = 1'b1; cyc(10);
    lock_raw = 1'b0; cyc(15);
    chk("R6", n_starts - base, 0);

    // R5: reset pin low holds off, release requests
    base = n_starts;
    rst_n_pin = 1'b0; cyc(8);
    chk("R5", n_starts - base, 0);
    rst_n_pin = 1'b1; cyc(15);
    chk("R5", n_starts - base, 1);

    // R6: mode 1 recalibrates on loss
    auto_rst_pin = 1'b1; cyc(5);
    base = n_starts;
    lock_raw = 1'b1; cyc(10);
    lock_raw = 1'b0; cyc(20);
    chk("R6", n_starts - base, 1);

    // R2 / R1: manual range from pins, two-edge latency
    ext_ctrl_pin = 1'b1; rst_n_pin = 1'b0; auto_rst_pin = 1'b1; range_lo_pin = 4'b0101;
    cyc(5);
    chk("R2", range_code, 6'b010101);
    range_lo_pin = 4'b1010;
    @(posedge clk); #2;
    chk("R1", range_code, 6'b010101);
    @(posedge clk); #2;
    chk("R1", range_code, 6'b011010);

    // R7: no requests in manual mode, none carried back
    base = n_starts;
    rst_n_pin = 1'b1; cyc(3); rst_n_pin = 1'b0; cyc(3); rst_n_pin = 1'b1;
    lock_raw = 1'b1; cyc(10); lock_raw = 1'b0; cyc(10);
    auto_rst_pin = 1'b0; ext_ctrl_pin = 1'b0; cyc(15);
    chk("R7", n_starts - base, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) lock_raw = ~lock_raw;
      if ($urandom_range(0, 149) == 0) begin
        ext_ctrl_pin = ($urandom_range(0, 2) == 0);
        rst_n_pin    = ($urandom_range(0, 5) != 0);
        auto_rst_pin = $urandom_range(0, 1);
        range_lo_pin = 4'($urandom_range(0, 15));
      end
      if ($urandom_range(0, 63) == 0) cal_code = 6'($urandom_range(0, 63));
    end
    cyc(4);
    finish_run();
  end
endmodule